// File: doc/BRIEF.md
# Data-Strobe Character Decoder

This block sits behind a bit-recovery front end on a serial data-strobe link. Each system clock it may receive a group of `CHUNK` recovered bits (one to four) with a valid flag, plus an activity flag that says a line transition was seen. It finds character alignment by hunting for the first NULL. After that it splits the bit stream into control and data characters, checks odd parity, and resolves escape sequences. It reports data bytes, packet markers, flow-control tokens and time codes as one-clock strobes.

The block also watches for link presence. It keeps a flag for "a transition was ever seen" and a flag for "alignment found". It raises a disconnect flag when the line goes quiet for `DISC_CLKS` clocks after activity began. The link controller above uses the sticky parity and escape error flags to tear the link down. Pulling the single enable input low returns the whole block to its idle state.

Top module: `ds_char_decoder`

## Requirements
- R1: While `rx_en` is low, every output is cleared after the next rising clock edge. This covers flags, strobes and held values.
- R2: `seen_edge` goes high after the first edge at which `line_act` is sampled high with `rx_en` high. It then stays high until `rx_en` is low.
- R3: Before alignment, incoming bits are only searched and are never decoded. `seen_null` goes high once the seven bits 1,1,1,0,1,0,0 arrive in that order. The next bit is then taken as a parity bit. `seen_null` stays high until `rx_en` is low.
- R4: After alignment, each character is built the same way. It starts with a parity bit, then a flag bit (1 = control, 0 = data). A control character has 2 more bits; its code is first bit + 2 × second bit, where 0 = FCT, 1 = EOP, 2 = EEP and 3 = ESC. A data character has 8 more bits, least significant first. Parity is odd: the previous character's payload bits, the parity bit and the flag bit XOR to 1.
- R5: A data character gives one clock of `nchar_stb` with `nchar_mark` = 0 and `nchar_byte` = the byte.
- R6: EOP gives one clock of `nchar_stb` with `nchar_mark` = 1 and `nchar_byte` = 0x00. EEP gives the same with `nchar_byte` = 0x01.
- R7: An FCT that does not follow an ESC gives one clock of `fct_stb`.
- R8: ESC followed by a data character gives one clock of `tcode_stb`, with `tcode_flags` = byte[7:6] and `tcode_value` = byte[5:0]. Every such time code is reported, with no sequence check. ESC followed by FCT (a NULL) gives no output.
- R9: ESC followed by ESC, EOP or EEP sets `esc_err`. The flag stays set until `rx_en` is low.
- R10: A parity mismatch after alignment sets `par_err`, which stays set until `rx_en` is low. No parity check is made before alignment.
- R11: Once `par_err` or `esc_err` is set, no strobe is issued until `rx_en` goes low.
- R12: Suppose `seen_edge` is high and `line_act` is sampled low at `DISC_CLKS` edges in a row. Then `disc_err` rises after the last of them. It clears after the next edge at which `line_act` is sampled high.
- R13: Each edge with `grp_valid` high takes `CHUNK` bits, with bit 0 the earliest; an edge with `grp_valid` low takes none. Results appear one edge after their group and do not depend on how the stream is split into groups. At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rx_en | input | 1 | Enable; low holds the block in its idle state |
| line_act | input | 1 | A line transition was seen this clock |
| grp_valid | input | 1 | `grp_bits` holds a valid group |
| grp_bits | input | CHUNK | Received bits, bit 0 earliest |
| seen_edge | output | 1 | A transition was seen since enable |
| seen_null | output | 1 | Alignment found (NULL received) |
| fct_stb | output | 1 | Flow-control token received |
| tcode_stb | output | 1 | Time code received |
| tcode_flags | output | 2 | Control bits of the last time code |
| tcode_value | output | 6 | Counter of the last time code |
| nchar_stb | output | 1 | Data byte or packet marker received |
| nchar_mark | output | 1 | 1 when the character is a marker |
| nchar_byte | output | 8 | Data byte, or 0x00 / 0x01 for EOP / EEP |
| disc_err | output | 1 | Disconnect timeout |
| par_err | output | 1 | Sticky parity error |
| esc_err | output | 1 | Sticky escape error |

## Verification
With three bits per group, a character can finish in the same group in which the next character's flag bit shows a parity failure. The character strobe and the rise of `par_err` then land in the same cycle. The bench builds this case: after a 15-bit alignment prefix, a data byte ends on the first bit of a group, and a badly parity-coded byte's flag falls on the last bit of that group. It expects that byte to be reported, `par_err` to be set, and every later character to be suppressed. The same event-list comparison runs again with idle gaps between groups, which checks that splitting the stream differently changes nothing.

// File: rtl/ds_dec_pkg.sv
package ds_dec_pkg;

    localparam int BYTE_W   = 8;
    localparam int HIST_W   = 6;
    localparam int POS_W    = 4;

    // Control-code values, first payload bit is the LSB
    typedef enum logic [1:0] {
        CC_FCT = 2'd0,
        CC_EOP = 2'd1,
        CC_EEP = 2'd2,
        CC_ESC = 2'd3
    } ctl_code_e;

    // Seven-bit alignment tail of a NULL (flag,ctl,ctl,parity,flag,ctl,ctl)
    localparam logic [HIST_W:0] NULL_TAIL = 7'b1110100;

    localparam logic [BYTE_W-1:0] MARK_NORMAL = 8'h00;
    localparam logic [BYTE_W-1:0] MARK_ERROR  = 8'h01;

    // Position index of the final bit of each character kind
    localparam logic [POS_W-1:0] CTRL_LAST = 4'd3;
    localparam logic [POS_W-1:0] DATA_LAST = 4'd9;

    typedef struct packed {
        logic                synced;
        logic                halted;
        logic [HIST_W-1:0]   hist;
        logic [POS_W-1:0]    pos;
        logic                is_ctrl;
        logic                par_run;
        logic                pay_xor;
        logic                esc_pend;
        logic [BYTE_W-1:0]   pay;
    } ds_state_t;

    typedef struct packed {
        logic                fct;
        logic                tcode;
        logic                nchar;
        logic                mark;
        logic                par_bad;
        logic                esc_bad;
        logic [BYTE_W-1:0]   byte_v;
    } ds_evt_t;

    function automatic ds_state_t idle_state();
        ds_state_t s;
        s = '0;
        return s;
    endfunction

    function automatic logic parity_good(logic run, logic flag_bit);
        return (run ^ flag_bit) == 1'b1;
    endfunction

endpackage

// File: rtl/ds_bit_step.sv
module ds_bit_step
    import ds_dec_pkg::*;
(
    input  ds_state_t cur,
    input  logic      bit_in,
    output ds_state_t nxt,
    output ds_evt_t   ev
);

    ctl_code_e code;

    always_comb begin
        nxt  = cur;
        ev   = '0;
        code = CC_FCT;
        if (!cur.halted) begin
            if (!cur.synced) begin
                nxt.hist = {cur.hist[HIST_W-2:0], bit_in};
                if ({cur.hist, bit_in} == NULL_TAIL) begin
                    nxt.synced   = 1'b1;
                    nxt.pos      = '0;
                    nxt.pay_xor  = 1'b0;
                    nxt.esc_pend = 1'b0;
                end
            end else if (cur.pos == 4'd0) begin
                nxt.par_run = cur.pay_xor ^ bit_in;
                nxt.pos     = 4'd1;
            end else if (cur.pos == 4'd1) begin
                if (!parity_good(cur.par_run, bit_in)) begin
                    nxt.halted = 1'b1;
                    ev.par_bad = 1'b1;
                end else begin
                    nxt.is_ctrl = bit_in;
                    nxt.pos     = 4'd2;
                    nxt.pay_xor = 1'b0;
                    nxt.pay     = '0;
                end
            end else begin
                nxt.pay[3'(cur.pos - 4'd2)] = bit_in;
                nxt.pay_xor = cur.pay_xor ^ bit_in;
                nxt.pos     = cur.pos + 4'd1;
                if (cur.is_ctrl && cur.pos == CTRL_LAST) begin
                    nxt.pos = '0;
                    code    = ctl_code_e'({bit_in, cur.pay[0]});
                    if (cur.esc_pend) begin
                        nxt.esc_pend = 1'b0;
                        if (code != CC_FCT) begin
                            nxt.halted = 1'b1;
                            ev.esc_bad = 1'b1;
                        end
                    end else begin
                        case (code)
                            CC_FCT: ev.fct = 1'b1;
                            CC_EOP: begin
                                ev.nchar  = 1'b1;
                                ev.mark   = 1'b1;
                                ev.byte_v = MARK_NORMAL;
                            end
                            CC_EEP: begin
                                ev.nchar  = 1'b1;
                                ev.mark   = 1'b1;
                                ev.byte_v = MARK_ERROR;
                            end
                            default: nxt.esc_pend = 1'b1;
                        endcase
                    end
                end else if (!cur.is_ctrl && cur.pos == DATA_LAST) begin
                    nxt.pos = '0;
                    ev.byte_v = nxt.pay;
                    if (cur.esc_pend) begin
                        nxt.esc_pend = 1'b0;
                        ev.tcode     = 1'b1;
                    end else begin
                        ev.nchar = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ds_bit_chain.sv
module ds_bit_chain
    import ds_dec_pkg::*;
#(
    parameter int CHUNK = 1
) (
    input  ds_state_t        st_in,
    input  logic [CHUNK-1:0] bits,
    output ds_state_t        st_out,
    output ds_evt_t          ev_out
);

    ds_state_t stage [CHUNK+1];
    ds_evt_t   evs   [CHUNK];

    assign stage[0] = st_in;

    for (genvar g = 0; g < CHUNK; g++) begin : g_step
        ds_bit_step u_step (
            .cur    (stage[g]),
            .bit_in (bits[g]),
            .nxt    (stage[g+1]),
            .ev     (evs[g])
        );
    end

    assign st_out = stage[CHUNK];

    // At most one character can complete within four bits, so OR-merge
    always_comb begin
        ev_out = '0;
        for (int i = 0; i < CHUNK; i++) begin
            ev_out = ds_evt_t'(ev_out | evs[i]);
        end
    end

endmodule

// File: rtl/ds_presence_timer.sv
module ds_presence_timer #(
    parameter int DISC_CLKS = 64
) (
    input  logic clk,
    input  logic rx_en,
    input  logic line_act,
    output logic seen_edge,
    output logic disc_err
);

    localparam int IW = $clog2(DISC_CLKS + 1);
    localparam logic [IW-1:0] LIM = IW'(DISC_CLKS - 1);

    logic [IW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (!rx_en) begin
            seen_edge <= 1'b0;
            disc_err  <= 1'b0;
            idle_q    <= '0;
        end else if (line_act) begin
            seen_edge <= 1'b1;
            disc_err  <= 1'b0;
            idle_q    <= '0;
        end else if (seen_edge && !disc_err) begin
            if (idle_q == LIM) begin
                disc_err <= 1'b1;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    assert_disc_needs_edge_R12: assert property (@(posedge clk) disable iff (!rx_en)
        disc_err |-> seen_edge);

    assert_disc_after_quiet_R12: assert property (@(posedge clk) disable iff (!rx_en)
        $rose(disc_err) |-> !$past(line_act));

    assert_edge_sticky_R2: assert property (@(posedge clk) disable iff (!rx_en)
        seen_edge |=> seen_edge);

endmodule

// File: rtl/ds_char_decoder.sv
module ds_char_decoder
    import ds_dec_pkg::*;
#(
    parameter int CHUNK     = 1,
    parameter int DISC_CLKS = 64
) (
    input  logic             clk,
    input  logic             rx_en,
    input  logic             line_act,
    input  logic             grp_valid,
    input  logic [CHUNK-1:0] grp_bits,
    output logic             seen_edge,
    output logic             seen_null,
    output logic             fct_stb,
    output logic             tcode_stb,
    output logic [1:0]       tcode_flags,
    output logic [5:0]       tcode_value,
    output logic             nchar_stb,
    output logic             nchar_mark,
    output logic [7:0]       nchar_byte,
    output logic             disc_err,
    output logic             par_err,
    output logic             esc_err
);

    ds_state_t st_q;
    ds_state_t st_d;
    ds_evt_t   ev;

    ds_bit_chain #(.CHUNK(CHUNK)) u_chain (
        .st_in  (st_q),
        .bits   (grp_bits),
        .st_out (st_d),
        .ev_out (ev)
    );

    ds_presence_timer #(.DISC_CLKS(DISC_CLKS)) u_timer (
        .clk       (clk),
        .rx_en     (rx_en),
        .line_act  (line_act),
        .seen_edge (seen_edge),
        .disc_err  (disc_err)
    );

    always_ff @(posedge clk) begin
        if (!rx_en) begin
            st_q        <= idle_state();
            fct_stb     <= 1'b0;
            tcode_stb   <= 1'b0;
            nchar_stb   <= 1'b0;
            tcode_flags <= '0;
            tcode_value <= '0;
            nchar_mark  <= 1'b0;
            nchar_byte  <= '0;
            par_err     <= 1'b0;
            esc_err     <= 1'b0;
        end else begin
            fct_stb   <= grp_valid && ev.fct;
            tcode_stb <= grp_valid && ev.tcode;
            nchar_stb <= grp_valid && ev.nchar;
            if (grp_valid) begin
                st_q    <= st_d;
                par_err <= par_err | ev.par_bad;
                esc_err <= esc_err | ev.esc_bad;
                if (ev.tcode) begin
                    tcode_flags <= ev.byte_v[7:6];
                    tcode_value <= ev.byte_v[5:0];
                end
                if (ev.nchar) begin
                    nchar_mark <= ev.mark;
                    nchar_byte <= ev.byte_v;
                end
            end
        end
    end

    assign seen_null = st_q.synced;

    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rx_en)
        $onehot0({fct_stb, tcode_stb, nchar_stb}));

    assert_par_sticky_R10: assert property (@(posedge clk) disable iff (!rx_en)
        par_err |=> par_err);

    assert_par_needs_sync_R10: assert property (@(posedge clk) disable iff (!rx_en)
        par_err |-> seen_null);

    assert_esc_sticky_R9: assert property (@(posedge clk) disable iff (!rx_en)
        esc_err |=> esc_err);

    assert_null_sticky_R3: assert property (@(posedge clk) disable iff (!rx_en)
        seen_null |=> seen_null);

    assert_quiet_after_err_R11: assert property (@(posedge clk) disable iff (!rx_en)
        (par_err || esc_err) |=> !(fct_stb || tcode_stb || nchar_stb));

endmodule

// File: tb/ds_char_decoder_tb.sv
module ds_char_decoder_tb_top;

    localparam int CH   = 3;
    localparam int DISC = 6;

    logic          clk = 1'b0;
    logic          rx_en = 1'b0;
    logic          line_act = 1'b0;
    logic          grp_valid = 1'b0;
    logic [CH-1:0] grp_bits = '0;
    logic          seen_edge, seen_null, fct_stb, tcode_stb, nchar_stb;
    logic          nchar_mark, disc_err, par_err, esc_err;
    logic [1:0]    tcode_flags;
    logic [5:0]    tcode_value;
    logic [7:0]    nchar_byte;

    ds_char_decoder #(.CHUNK(CH), .DISC_CLKS(DISC)) dut_i (
        .clk(clk), .rx_en(rx_en), .line_act(line_act), .grp_valid(grp_valid),
        .grp_bits(grp_bits), .seen_edge(seen_edge), .seen_null(seen_null),
        .fct_stb(fct_stb), .tcode_stb(tcode_stb), .tcode_flags(tcode_flags),
        .tcode_value(tcode_value), .nchar_stb(nchar_stb), .nchar_mark(nchar_mark),
        .nchar_byte(nchar_byte), .disc_err(disc_err), .par_err(par_err),
        .esc_err(esc_err)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit bq[$];
    int expq[$];
    int gotq[$];
    bit prevx = 1'b0;

    // Event log: 1000+byte data, 2000+byte marker, 3000 FCT, 4000+code time code
    always @(negedge clk) begin
        if (nchar_stb) gotq.push_back((nchar_mark ? 2000 : 1000) + int'(nchar_byte));
        if (fct_stb)   gotq.push_back(3000);
        if (tcode_stb) gotq.push_back(4000 + int'({tcode_flags, tcode_value}));
    end

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic put_ctrl(input logic [1:0] c, input bit rep);
        bq.push_back(prevx);          // parity: prev ^ p ^ 1 == 1
        bq.push_back(1'b1);
        bq.push_back(c[0]);
        bq.push_back(c[1]);
        prevx = c[0] ^ c[1];
        if (rep) begin
            if (c == 2'd0) expq.push_back(3000);
            if (c == 2'd1) expq.push_back(2000);
            if (c == 2'd2) expq.push_back(2001);
        end
    endtask

    task automatic put_data(input logic [7:0] v, input int kind, input bit bad);
        bq.push_back(bad ? prevx : ~prevx);
        bq.push_back(1'b0);
        for (int i = 0; i < 8; i++) bq.push_back(v[i]);
        prevx = ^v;
        if (kind == 1) expq.push_back(1000 + int'(v));
        if (kind == 4) expq.push_back(4000 + int'(v));
    endtask

    task automatic put_null();
        put_ctrl(2'd3, 1'b0);
        put_ctrl(2'd0, 1'b0);
    endtask

    task automatic put_tc(input logic [7:0] v);
        put_ctrl(2'd3, 1'b0);
        put_data(v, 4, 1'b0);
    endtask

    task automatic pad();
        while (bq.size() % CH != 0) put_null();
    endtask

    task automatic feed(input bit gaps);
        int k = 0;
        while (bq.size() > 0) begin
            @(negedge clk);
            if (gaps && (k % 2 == 1)) begin
                grp_valid = 1'b0;
                line_act  = 1'b0;
                grp_bits  = '1;
            end else begin
                grp_valid = 1'b1;
                line_act  = 1'b1;
                for (int j = 0; j < CH; j++) grp_bits[j] = bq.pop_front();
            end
            k++;
        end
        @(negedge clk);
        grp_valid = 1'b0;
        line_act  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rx_en = 1'b0; grp_valid = 1'b0; line_act = 1'b0;
        repeat (2) @(negedge clk);
        prevx = 1'b0;
        bq.delete(); expq.delete(); gotq.delete();
        rx_en = 1'b1;
    endtask

    task automatic cmp_events(input string req);
        chk(gotq.size() == expq.size(), req, gotq.size(), expq.size());
        for (int i = 0; i < gotq.size() && i < expq.size(); i++)
            chk(gotq[i] == expq[i], req, gotq[i], expq[i]);
    endtask

    task automatic all_quiet(input string req);
        chk({seen_edge, seen_null, fct_stb, tcode_stb, nchar_stb, nchar_mark,
             disc_err, par_err, esc_err} == '0 && tcode_flags == 0 &&
            tcode_value == 0 && nchar_byte == 0, req,
            int'({seen_edge, seen_null, par_err, esc_err, disc_err}), 0);
    endtask

    task automatic sweep(input bit gaps);
        do_reset();
        put_null();
        for (int i = 0; i < 256; i++) begin
            put_data(8'(i), 1, 1'b0);                    // R5
            if (i % 16 == 0)  put_ctrl(2'd1, 1'b1);      // R6 EOP
            if (i % 16 == 5)  put_ctrl(2'd2, 1'b1);      // R6 EEP
            if (i % 7 == 0)   put_ctrl(2'd0, 1'b1);      // R7
            if (i % 32 == 3)  put_tc(8'(i) ^ 8'h5A);     // R8
            if (i % 11 == 0)  put_null();                // R8 NULL silent
        end
        pad();
        feed(gaps);
        cmp_events(gaps ? "R13 gapped stream" : "R5/R6/R7/R8 sweep");
        chk(par_err == 1'b0, "R4 parity accepted", par_err, 0);
        chk(esc_err == 1'b0, "R4 no escape error", esc_err, 0);
        chk(seen_null == 1'b1, "R3 aligned", seen_null, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        all_quiet("R1 reset state");

        // R2 / R12 presence and disconnect
        do_reset();
        repeat (DISC + 3) @(negedge clk);
        chk(seen_edge == 1'b0, "R2 no edge yet", seen_edge, 0);
        chk(disc_err == 1'b0, "R12 no timeout before edge", disc_err, 0);
        line_act = 1'b1;
        @(negedge clk);
        chk(seen_edge == 1'b1, "R2 edge seen", seen_edge, 1);
        line_act = 1'b0;
        repeat (DISC - 1) @(negedge clk);
        chk(disc_err == 1'b0, "R12 one short of limit", disc_err, 0);
        @(negedge clk);
        chk(disc_err == 1'b1, "R12 timeout at limit", disc_err, 1);
        line_act = 1'b1;
        @(negedge clk);
        chk(disc_err == 1'b0, "R12 cleared by edge", disc_err, 0);
        line_act = 1'b0;

        // R3 / R4 / R5..R8 sweeps, R13 grouping
        sweep(1'b0);
        sweep(1'b1);

        // R3 / R10 junk before alignment, then same-cycle char + parity error
        do_reset();
        bq.push_back(1); bq.push_back(0); bq.push_back(1); bq.push_back(1);
        bq.push_back(0); bq.push_back(0); bq.push_back(1);
        put_null();
        feed(1'b0);
        chk(seen_null == 1'b1, "R3 aligned after junk", seen_null, 1);
        chk(par_err == 1'b0, "R10 no check before alignment", par_err, 0);
        chk(gotq.size() == 0, "R3 junk not decoded", gotq.size(), 0);
        put_data(8'h5A, 1, 1'b0);
        put_data(8'h21, 0, 1'b1);
        put_data(8'h22, 0, 1'b0);
        put_ctrl(2'd0, 1'b0);
        pad();
        feed(1'b0);
        chk(par_err == 1'b1, "R10 parity error", par_err, 1);
        chk(esc_err == 1'b0, "R10 not escape", esc_err, 0);
        cmp_events("R11 quiet after parity error");

        // R1 enable low clears sticky state
        @(negedge clk);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        all_quiet("R1 clear after error");

        // R9 / R11 escape errors
        for (int c = 1; c <= 3; c++) begin
            do_reset();
            put_null();
            put_data(8'h33, 1, 1'b0);
            put_ctrl(2'd3, 1'b0);
            put_ctrl(2'(c), 1'b0);
            put_data(8'h44, 0, 1'b0);
            put_tc(8'h12);
            expq.pop_back();
            pad();
            feed(1'b0);
            chk(esc_err == 1'b1, "R9 escape error", esc_err, 1);
            chk(par_err == 1'b0, "R9 no parity error", par_err, 0);
            cmp_events("R11 quiet after escape error");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule